// File: doc/BRIEF.md
# Infrared Code Receive Buffer with Interrupt Status

This block sits between an infrared sample decoder that emits one code byte at a time and a processor bus. Each byte offered on the push input is stored in a first-in first-out buffer whose depth is a parameter (16 or 64 entries). A bus read at the data offset hands back the oldest byte and removes it. The producer also pulses a marker when a packet finishes.

Three sticky flags record what happened: a byte was lost because the buffer was full, a packet ended, and the fill count rose above a programmed trigger level. The status word carries these flags together with the current fill count. Software clears a flag by writing a one to its bit. A single interrupt line is raised whenever any flag is set and its enable bit is on. Register reads return data in the same cycle the read strobe is high, and every access takes effect at the next clock edge.

Top module: `ir_rx_buffer`

## Requirements
- R1: After reset, the fill count, all three flags, the interrupt enables, the trigger level and the control word are zero, and irq is low.
- R2: A byte on the push input is stored only when control offset 0x00 has bit 0 (block on) and bit 1 (receive on) both set. Otherwise the byte is ignored and the fill count does not change.
- R3: A byte pushed while the buffer holds DEPTH bytes, with no pop in the same cycle, is dropped and sets the overflow flag (status bit 0). The fill count never exceeds DEPTH.
- R4: A read at offset 0x20 returns the oldest byte in bits 7:0, with zeros above it, and lowers the count by one at the next edge. On an empty buffer the read returns 0 and the count stays unchanged.
- R5: A push and a pop in the same cycle leave the count unchanged. The pushed byte is accepted even when the buffer is full, and no overflow is flagged.
- R6: A pulse on the packet-end input sets the packet-end flag (status bit 1) at the next edge.
- R7: The trigger level is held in bits 8 and up of offset 0x2C (log2(DEPTH) bits) and reads back there. The data-available flag (status bit 4) is set at the edge after the count first exceeds the level.
- R8: Offset 0x30 reports the flags in bits 0, 1 and 4 and the fill count in bits 8 and up (log2(DEPTH)+1 bits).
- R9: Writing to 0x30 clears each flag whose bit is written as 1 and leaves the others alone. Writing 0xFF clears all flags. A set event in the same cycle wins over the clear.
- R10: irq is high exactly when some flag is set and its enable bit at offset 0x2C is set: bit 0 for overflow, bit 1 for packet end, bit 4 for data available.
- R11: Offsets 0x10 (receive configuration) and 0x34 (sample configuration) hold any 32-bit value written and return it on read. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops at 0x20) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| code_valid | input | 1 | Code byte push strobe |
| code_byte | input | 8 | Code byte |
| code_last | input | 1 | Packet-end pulse |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions are provoked on purpose. In one, a byte push and a data read land in the same cycle while the buffer is full. The bench checks that the count holds, that no overflow flag appears, and that the pushed byte drains out last. In the other, the packet-end pulse and a write-one-to-clear of that same flag fall on one edge, and the flag must read back as still set. A scoreboard queue holds every byte the bench expects the buffer to accept, and the monitor compares each data read against the head of that queue. A dropped overflow byte therefore shows up as a mismatch in drain order.

// File: rtl/ir_rx_buffer.sv
module ir_rx_buffer #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        code_valid,
  input  logic [7:0]  code_byte,
  input  logic        code_last,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [7:0] A_CTRL = 8'h00, A_RXCFG = 8'h10, A_DATA = 8'h20,
                         A_IEN  = 8'h2C, A_STAT  = 8'h30, A_SMP  = 8'h34;

  logic [1:0]    ctrl;
  logic [31:0]   rxcfg, smpcfg;
  logic [2:0]    ien;
  logic [AW-1:0] lvl;
  logic          ovf_f, pend_f, avail_f;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire full     = (cnt == CW'(DEPTH));
  wire rx_on    = &ctrl;
  wire pop      = bus_rd && (bus_addr == A_DATA) && (cnt != '0);
  wire accept   = code_valid && rx_on && (!full || pop);
  wire ovf_ev   = code_valid && rx_on && full && !pop;
  wire avail_ev = (cnt > {1'b0, lvl});
  wire [7:0] clr = (bus_wr && bus_addr == A_STAT) ? bus_wdata[7:0] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; rxcfg <= '0; smpcfg <= '0; ien <= '0; lvl <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL:  ctrl   <= bus_wdata[1:0];
        A_RXCFG: rxcfg  <= bus_wdata;
        A_SMP:   smpcfg <= bus_wdata;
        A_IEN: begin
          ien <= {bus_wdata[4], bus_wdata[1], bus_wdata[0]};
          lvl <= bus_wdata[8 +: AW];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_f <= 1'b0; pend_f <= 1'b0; avail_f <= 1'b0;
    end else begin
      ovf_f   <= ovf_ev    | (ovf_f   & ~clr[0]);
      pend_f  <= code_last | (pend_f  & ~clr[1]);
      avail_f <= avail_ev  | (avail_f & ~clr[4]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (accept) wp <= wp + 1'b1;
      if (pop)    rp <= rp + 1'b1;
      cnt <= cnt + CW'(accept) - CW'(pop);
    end
  end

  always_ff @(posedge clk)
    if (accept) mem[wp] <= code_byte;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = {30'd0, ctrl};
        A_RXCFG: bus_rdata = rxcfg;
        A_DATA:  bus_rdata = (cnt != '0) ? {24'd0, mem[rp]} : '0;
        A_IEN: begin
          bus_rdata[8 +: AW] = lvl;
          bus_rdata[4] = ien[2];
          bus_rdata[1:0] = ien[1:0];
        end
        A_STAT: begin
          bus_rdata[8 +: CW] = cnt;
          bus_rdata[4] = avail_f;
          bus_rdata[1:0] = {pend_f, ovf_f};
        end
        A_SMP:   bus_rdata = smpcfg;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = (ovf_f & ien[0]) | (pend_f & ien[1]) | (avail_f & ien[2]);
endmodule

module ir_rx_buffer_chk #(
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wr,
  input logic                     bus_rd,
  input logic [7:0]               bus_addr,
  input logic [31:0]              bus_wdata,
  input logic [31:0]              bus_rdata,
  input logic                     code_valid,
  input logic                     code_last,
  input logic                     rx_on,
  input logic                     ovf_f,
  input logic                     pend_f,
  input logic [$clog2(DEPTH):0]   cnt
);
  localparam int CW = $clog2(DEPTH) + 1;
  wire is_full = (cnt == CW'(DEPTH));
  wire pop_rd  = bus_rd && bus_addr == 8'h20;

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_full_push_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && rx_on && is_full && !pop_rd) |=> ovf_f);
  assert_pkt_end_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    code_last |=> pend_f);
  assert_idle_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_valid && !bus_rd) |=> $stable(cnt));
  assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_rd && cnt == '0) |-> bus_rdata == 32'd0);
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_f && !(bus_wr && bus_addr == 8'h30 && bus_wdata[0])) |=> ovf_f);
endmodule

bind ir_rx_buffer ir_rx_buffer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .code_valid(code_valid), .code_last(code_last), .rx_on(rx_on),
  .ovf_f(ovf_f), .pend_f(pend_f), .cnt(cnt)
);

// File: tb/tb_ir_rx_buffer.sv
module tb_ir_rx_buffer;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0, code_valid = 0, code_last = 0;
  logic [7:0] bus_addr = 0, code_byte = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit enabled = 0, done = 0;
  logic [7:0] q[$];
  logic [31:0] v;

  always #2 clk = ~clk;

  ir_rx_buffer #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (bus_rd && bus_addr == 8'h20)
      chk("R4 data pop", bus_rdata, (q.size() != 0) ? {24'd0, q.pop_front()} : 32'd0);

  task automatic reg_wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1 bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic reg_rd(logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1 bus_rd = 1; bus_addr = a;
    @(negedge clk); d = bus_rdata;
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic push_b(logic [7:0] b);
    @(posedge clk); #1 code_valid = 1; code_byte = b;
    if (enabled && q.size() < DEPTH) q.push_back(b);
    @(posedge clk); #1 code_valid = 0;
  endtask

  task automatic push_pop(logic [7:0] b);
    @(posedge clk); #1 code_valid = 1; code_byte = b; bus_rd = 1; bus_addr = 8'h20;
    @(negedge clk); #1 q.push_back(b);
    @(posedge clk); #1 code_valid = 0; bus_rd = 0;
  endtask

  function automatic logic [31:0] cnt_of(logic [31:0] s);
    return 32'(s[8 +: CW]);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    reg_rd(8'h30, v); chk("R1 status", v, 0);
    reg_rd(8'h00, v); chk("R1 control", v, 0);
    reg_rd(8'h2C, v); chk("R1 enables", v, 0);
    chk("R1 irq", 32'(irq), 0);

    push_b(8'h11);
    reg_rd(8'h30, v); chk("R2 disabled push ignored", cnt_of(v), 0);

    reg_wr(8'h00, 32'h3); enabled = 1;
    reg_wr(8'h2C, 32'h0000_0700);
    reg_rd(8'h2C, v); chk("R7 level readback", v, 32'h700);
    for (int i = 0; i < 5; i++) push_b(8'hA0 + 8'(i));
    reg_rd(8'h30, v); chk("R8 count field", cnt_of(v), 5);
    chk("R7 below level", 32'(v[4]), 0);
    reg_rd(8'h20, v); reg_rd(8'h20, v);
    reg_rd(8'h30, v); chk("R8 count after pops", cnt_of(v), 3);

    for (int i = 0; i < 13; i++) push_b(8'hB0 + 8'(i));
    reg_rd(8'h30, v); chk("R7 above level", 32'(v[4]), 1);
    chk("R8 full count", cnt_of(v), DEPTH);
    chk("R3 no overflow yet", 32'(v[0]), 0);

    push_b(8'hEE);
    reg_rd(8'h30, v); chk("R3 overflow flag", 32'(v[0]), 1);
    chk("R3 count capped", cnt_of(v), DEPTH);

    reg_wr(8'h30, 32'h01);
    reg_rd(8'h30, v); chk("R9 clear overflow only", v[4:0], 5'h10);

    push_pop(8'h5C);
    reg_rd(8'h30, v); chk("R5 count held", cnt_of(v), DEPTH);
    chk("R5 no overflow", 32'(v[0]), 0);

    for (int i = 0; i < DEPTH; i++) reg_rd(8'h20, v);
    reg_rd(8'h20, v); chk("R4 empty read", v, 0);
    reg_rd(8'h30, v); chk("R4 empty count", cnt_of(v), 0);

    reg_wr(8'h30, 32'h10);
    reg_rd(8'h30, v); chk("R9 clear avail", v, 0);

    @(posedge clk); #1 code_last = 1; @(posedge clk); #1 code_last = 0;
    reg_rd(8'h30, v); chk("R6 packet end", v, 32'h2);
    chk("R10 irq masked", 32'(irq), 0);
    reg_wr(8'h2C, 32'h0000_0701);
    chk("R10 irq other source", 32'(irq), 0);
    reg_wr(8'h2C, 32'h0000_0702);
    chk("R10 irq enabled", 32'(irq), 1);
    reg_wr(8'h30, 32'h02);
    chk("R10 irq after clear", 32'(irq), 0);

    @(posedge clk); #1 code_last = 1; bus_wr = 1; bus_addr = 8'h30; bus_wdata = 32'h02;
    @(posedge clk); #1 code_last = 0; bus_wr = 0;
    reg_rd(8'h30, v); chk("R9 set wins over clear", 32'(v[1]), 1);
    reg_wr(8'h30, 32'hFF);
    reg_rd(8'h30, v); chk("R9 clear all", v, 0);

    reg_wr(8'h10, 32'hDEADBEEF);
    reg_wr(8'h34, 32'h0000_1234);
    reg_rd(8'h10, v); chk("R11 rx config", v, 32'hDEADBEEF);
    reg_rd(8'h34, v); chk("R11 sample config", v, 32'h1234);
    reg_rd(8'h08, v); chk("R11 unmapped", v, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule